// File: doc/BRIEF.md
# Interrupt Pin Service Unit

This block watches a set of interrupt input pins and decides, from each pin's redirection settings, when a delivery to the processors is due. Each pin's raw input can be inverted by a polarity bit. A pin is either edge-triggered or level-triggered and can be masked. The redirection settings come in as static configuration inputs: the vector, the trigger kind, the delivery kind, the destination, the polarity and the mask. The register interface that holds them belongs to the surrounding design.

Pins that need service are picked lowest index first. The chosen pin's fields are presented as a single delivery request on a valid/ready handshake. The processor side completes the request by raising ready together with the set of CPUs that the destination resolves to. The block keeps only the CPUs that are present, forces pin 0 to CPU 0, and reports the resulting injection set one cycle later. A level-triggered delivery that reaches at least one CPU sets a per-pin busy flag that blocks further deliveries from that pin. End-of-interrupt messages carry a vector. They are matched against every pin. A level-type message clears the busy flag on each matching pin, and that pin is serviced again if its input is still active.

Top module: `irq_pin_service`

## Requirements
- R1: The effective level of a pin is `pin_raw` XOR `cfg_polarity`. With polarity 1, a raw 1 is inactive and a raw 0 is active.
- R2: An unmasked level-triggered pin (`cfg_level_trig`=1) whose busy flag is clear requests service while its effective level is high. `dlv_valid` rises at the second rising clock edge after the input change. A low level makes no request.
- R3: An edge-triggered pin (`cfg_level_trig`=0) latches one request on each rising transition of its effective level. The latch is cleared when the pin is selected, so a level that stays high gives exactly one delivery. The latency is the same as in R2.
- R4: A masked pin is never selected. An edge latched while masked, or pending when the mask is set, is discarded, and unmasking later does not deliver it.
- R5: When a delivery of a level-triggered pin completes with a non-zero `inj_mask`, that pin's busy flag is set. The pin then makes no new request while its input stays active.
- R6: When a delivery completes with an all-zero `inj_mask`, the busy flag stays clear. A level pin that is still active is requested again on the second edge after completion.
- R7: An end-of-interrupt with `eoi_level`=1 clears the busy flag of every pin whose `cfg_vector` equals `eoi_vector`. A matching unmasked pin that is still active is requested again one edge later.
- R8: `eoi_hit` bit i is 1 for exactly the cycle after `eoi_valid` when pin i's vector matches, for both message types. A message with `eoi_level`=0 leaves the busy flags unchanged.
- R9: When several pins request service, the lowest pin index is presented first.
- R10: At most one request is outstanding. While `dlv_valid` is 1 and `dlv_ready` is 0, the request and all its fields stay unchanged. After a completion, `dlv_valid` is 0 for at least one cycle.
- R11: A delivery from pin 0 injects to CPU 0 only (`inj_mask` bit 0), whatever `dlv_targets` holds.
- R12: On completion (`dlv_valid` and `dlv_ready` both 1), the next cycle shows `inj_valid`=1 and `inj_mask` = `dlv_targets` AND `cpu_present`.
- R13: After reset, `dlv_valid`, `inj_valid` and `eoi_hit` are 0 and all busy flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NUM_PINS | Raw interrupt inputs |
| cfg_polarity | input | NUM_PINS | Per-pin input inversion |
| cfg_level_trig | input | NUM_PINS | Per-pin trigger kind, 1 = level |
| cfg_mask | input | NUM_PINS | Per-pin mask |
| cfg_vector | input | NUM_PINS*8 | Per-pin vector, pin i at bits [8i+7:8i] |
| cfg_dmode | input | NUM_PINS*3 | Per-pin delivery kind |
| cfg_dest | input | NUM_PINS*8 | Per-pin destination field |
| cpu_present | input | NUM_CPU | CPUs that exist |
| dlv_valid | output | 1 | Delivery request pending |
| dlv_ready | input | 1 | Processor side completes the request |
| dlv_pin | output | $clog2(NUM_PINS) | Pin being delivered |
| dlv_vector | output | 8 | Vector of the request |
| dlv_level | output | 1 | Trigger kind of the request |
| dlv_dmode | output | 3 | Delivery kind of the request |
| dlv_dest | output | 8 | Destination field of the request |
| dlv_targets | input | NUM_CPU | Resolved CPU set, sampled with ready |
| inj_valid | output | 1 | Injection report pulse |
| inj_mask | output | NUM_CPU | CPUs actually injected |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | 8 | Vector carried by the message |
| eoi_level | input | 1 | Message is level type |
| eoi_hit | output | NUM_PINS | Pins matched by the last message |

## Verification
A busy flag stuck at 1 shows up as a missing re-delivery two edges after a level end-of-interrupt. A busy flag wrongly cleared shows up as a second `dlv_valid` within two cycles of a completion while the pin is still held active. A lost or sticky edge latch is visible as a missing or repeated delivery within the same two-edge latency. Arbitration and pin-0 forcing errors appear on `dlv_pin` and `inj_mask` in the very cycle the request is presented or reported.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

    localparam int VEC_W   = 8;
    localparam int DMODE_W = 3;
    localparam int DEST_W  = 8;

    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic               level;
        logic [DMODE_W-1:0] dmode;
        logic [DEST_W-1:0]  dest;
    } dlv_fields_t;

    function automatic logic vec_match(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
    import irq_svc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic             polarity,
    input  logic             level_trig,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic             take,
    input  logic             done_inj,
    output logic             req,
    output logic             eoi_match,
    output logic             remote
);
    logic eff, eff_q, rise, edge_pend;

    assign eff       = raw ^ polarity;
    assign rise      = eff & ~eff_q;
    assign eoi_match = eoi_valid & vec_match(vector, eoi_vector);

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_q     <= 1'b0;
            edge_pend <= 1'b0;
            remote    <= 1'b0;
        end else begin
            eff_q     <= eff;
            edge_pend <= ~level_trig & ~masked & ((edge_pend & ~take) | rise);
            if (done_inj && level_trig)
                remote <= 1'b1;
            else if (eoi_match && eoi_level)
                remote <= 1'b0;
        end
    end

    always_comb begin
        if (level_trig)
            req = eff_q & ~masked & ~remote;
        else
            req = edge_pend & ~masked;
    end

    // R4: the arbiter never selects a masked pin
    a_r4_masked_not_taken: assert property (@(posedge clk) disable iff (rst)
        masked |-> !take);

    // R3: a taken edge request without a new edge is gone afterwards
    a_r3_edge_one_shot: assert property (@(posedge clk) disable iff (rst)
        (take && !level_trig && !rise) |=> !edge_pend);

    // R7: level EOI match clears the busy flag unless a completion sets it
    a_r7_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (eoi_match && eoi_level && !done_inj) |=> !remote);

endmodule

// File: rtl/irq_lowest_arb.sv
module irq_lowest_arb #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_CPU  = 4,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PINS-1:0]         pin_raw,
    input  logic [NUM_PINS-1:0]         cfg_polarity,
    input  logic [NUM_PINS-1:0]         cfg_level_trig,
    input  logic [NUM_PINS-1:0]         cfg_mask,
    input  logic [NUM_PINS*VEC_W-1:0]   cfg_vector,
    input  logic [NUM_PINS*DMODE_W-1:0] cfg_dmode,
    input  logic [NUM_PINS*DEST_W-1:0]  cfg_dest,
    input  logic [NUM_CPU-1:0]          cpu_present,
    output logic                        dlv_valid,
    input  logic                        dlv_ready,
    output logic [IDX_W-1:0]            dlv_pin,
    output logic [VEC_W-1:0]            dlv_vector,
    output logic                        dlv_level,
    output logic [DMODE_W-1:0]          dlv_dmode,
    output logic [DEST_W-1:0]           dlv_dest,
    input  logic [NUM_CPU-1:0]          dlv_targets,
    output logic                        inj_valid,
    output logic [NUM_CPU-1:0]          inj_mask,
    input  logic                        eoi_valid,
    input  logic [VEC_W-1:0]            eoi_vector,
    input  logic                        eoi_level,
    output logic [NUM_PINS-1:0]         eoi_hit
);
    localparam logic [NUM_CPU-1:0] CPU0_ONLY = NUM_CPU'(1);

    logic [NUM_PINS-1:0] req_vec, grant, take, done_vec, match_vec, remote_vec;
    logic [IDX_W-1:0]    sel_idx;
    logic                sel_any, busy, done;
    dlv_fields_t         cur, sel_fields;
    logic [NUM_CPU-1:0]  fire_set;

    assign done = busy & dlv_ready;
    assign take = grant & {NUM_PINS{~busy}};

    always_comb begin
        if (dlv_pin == '0)
            fire_set = CPU0_ONLY & cpu_present;
        else
            fire_set = dlv_targets & cpu_present;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign done_vec[i] = done && (dlv_pin == IDX_W'(i)) && (|fire_set);
        irq_pin_slice u_slice (
            .clk        (clk),
            .rst        (rst),
            .raw        (pin_raw[i]),
            .polarity   (cfg_polarity[i]),
            .level_trig (cfg_level_trig[i]),
            .masked     (cfg_mask[i]),
            .vector     (cfg_vector[i*VEC_W +: VEC_W]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .eoi_level  (eoi_level),
            .take       (take[i]),
            .done_inj   (done_vec[i]),
            .req        (req_vec[i]),
            .eoi_match  (match_vec[i]),
            .remote     (remote_vec[i])
        );
    end

    irq_lowest_arb #(.N(NUM_PINS)) u_arb (
        .req   (req_vec),
        .grant (grant),
        .idx   (sel_idx),
        .any   (sel_any)
    );

    always_comb begin
        sel_fields.vector = cfg_vector[sel_idx*VEC_W +: VEC_W];
        sel_fields.level  = cfg_level_trig[sel_idx];
        sel_fields.dmode  = cfg_dmode[sel_idx*DMODE_W +: DMODE_W];
        sel_fields.dest   = cfg_dest[sel_idx*DEST_W +: DEST_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            dlv_pin   <= '0;
            cur       <= '0;
            inj_valid <= 1'b0;
            inj_mask  <= '0;
            eoi_hit   <= '0;
        end else begin
            inj_valid <= done;
            inj_mask  <= done ? fire_set : '0;
            eoi_hit   <= match_vec;
            if (done) begin
                busy <= 1'b0;
            end else if (!busy && sel_any) begin
                busy    <= 1'b1;
                dlv_pin <= sel_idx;
                cur     <= sel_fields;
            end
        end
    end

    assign dlv_valid  = busy;
    assign dlv_vector = cur.vector;
    assign dlv_level  = cur.level;
    assign dlv_dmode  = cur.dmode;
    assign dlv_dest   = cur.dest;

    // R10: a stalled request holds still
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) && $stable(dlv_vector)
                                       && $stable(dlv_dest) && $stable(dlv_dmode)));

    // R10: a gap follows every completion
    a_r10_gap_after_done: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready) |=> !dlv_valid);

    // R5: level delivery that injected leaves the pin busy
    a_r5_busy_set: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready && dlv_level && (|fire_set)) |=> remote_vec[$past(dlv_pin)]);

    // R11: pin 0 reaches CPU 0 only
    a_r11_pin0_cpu0: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready && dlv_pin == '0) |=> (inj_mask[NUM_CPU-1:1] == '0));

    // R12: injection never names an absent CPU
    a_r12_present_only: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready) |=> (inj_valid && ((inj_mask & ~$past(cpu_present)) == '0)));

    // R8: hits only follow a message
    a_r8_hit_follows_msg: assert property (@(posedge clk) disable iff (rst)
        (|eoi_hit) |-> $past(eoi_valid));

    // R9: one grant at most
    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));

endmodule

// File: tb/irq_pin_service_test.sv
`timescale 1ns/1ps
module irq_pin_service_test;
    localparam int NP = 8;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]   pin_raw = '0, cfg_polarity = '0, cfg_level_trig = '0, cfg_mask = '1;
    logic [NP*8-1:0] cfg_vector, cfg_dest;
    logic [NP*3-1:0] cfg_dmode;
    logic [NC-1:0]   cpu_present = '1;
    logic            dlv_ready = 1'b0;
    logic [NC-1:0]   dlv_targets = '0;
    logic            eoi_valid = 1'b0, eoi_level = 1'b0;
    logic [7:0]      eoi_vector = '0;
    logic            dlv_valid, dlv_level, inj_valid;
    logic [2:0]      dlv_pin, dlv_dmode;
    logic [7:0]      dlv_vector, dlv_dest;
    logic [NC-1:0]   inj_mask;
    logic [NP-1:0]   eoi_hit;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_pin_service #(.NUM_PINS(NP), .NUM_CPU(NC)) uut (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .cfg_polarity(cfg_polarity),
        .cfg_level_trig(cfg_level_trig), .cfg_mask(cfg_mask), .cfg_vector(cfg_vector),
        .cfg_dmode(cfg_dmode), .cfg_dest(cfg_dest), .cpu_present(cpu_present),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
        .dlv_vector(dlv_vector), .dlv_level(dlv_level), .dlv_dmode(dlv_dmode),
        .dlv_dest(dlv_dest), .dlv_targets(dlv_targets), .inj_valid(inj_valid),
        .inj_mask(inj_mask), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .eoi_level(eoi_level), .eoi_hit(eoi_hit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_idle(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            tick(1);
            chk(dlv_valid == 1'b0, tag, 32'(dlv_valid), 0);
        end
    endtask

    task automatic expect_req(input int pin, input string tag);
        chk(dlv_valid == 1'b1 && dlv_pin == 3'(pin), tag, {dlv_valid, 28'h0, dlv_pin}, {1'b1, 28'h0, 3'(pin)});
    endtask

    task automatic complete(input logic [NC-1:0] tg, input logic [NC-1:0] exp_inj, input string tag);
        dlv_ready   = 1'b1;
        dlv_targets = tg;
        tick(1);
        dlv_ready   = 1'b0;
        dlv_targets = '0;
        chk(inj_valid == 1'b1 && inj_mask == exp_inj, tag, {inj_valid, 27'h0, inj_mask}, {1'b1, 27'h0, exp_inj});
        chk(dlv_valid == 1'b0, "R10 gap after completion", 32'(dlv_valid), 0);
    endtask

    task automatic send_eoi(input logic [7:0] v, input logic lvl, input logic [NP-1:0] exp_hit, input string tag);
        eoi_valid  = 1'b1;
        eoi_vector = v;
        eoi_level  = lvl;
        tick(1);
        eoi_valid  = 1'b0;
        chk(eoi_hit == exp_hit, tag, 32'(eoi_hit), 32'(exp_hit));
        tick(1);
        chk(eoi_hit == '0, "R8 hit lasts one cycle", 32'(eoi_hit), 0);
    endtask

    task automatic t_reset;
        chk(dlv_valid == 1'b0, "R13 valid after reset", 32'(dlv_valid), 0);
        chk(inj_valid == 1'b0, "R13 inj after reset", 32'(inj_valid), 0);
        chk(eoi_hit == '0, "R13 hit after reset", 32'(eoi_hit), 0);
    endtask

    task automatic t_level;
        cfg_level_trig[3] = 1'b1; cfg_mask[3] = 1'b0;
        pin_raw[3] = 1'b1;
        tick(1);
        chk(dlv_valid == 1'b0, "R2 latency one edge", 32'(dlv_valid), 0);
        tick(1);
        expect_req(3, "R2 level request");
        chk(dlv_vector == 8'h33 && dlv_level == 1'b1 && dlv_dest == 8'hA3 && dlv_dmode == 3'd3,
            "R2 request fields", {dlv_vector, dlv_dest}, {8'h33, 8'hA3});
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk(dlv_valid && dlv_pin == 3'd3 && dlv_vector == 8'h33, "R10 held while stalled", 32'(dlv_pin), 3);
        end
        complete(4'b0010, 4'b0010, "R12 injection set");
        expect_idle(4, "R5 busy blocks redelivery");
        send_eoi(8'h33, 1'b1, 8'b0000_1000, "R8 hit on pin 3");
        expect_req(3, "R7 redelivery after level EOI");
        complete(4'b0001, 4'b0001, "R12 second injection");
        pin_raw[3] = 1'b0;
        send_eoi(8'h33, 1'b1, 8'b0000_1000, "R8 hit with pin low");
        expect_idle(3, "R2 no request when low");
        cfg_mask[3] = 1'b1;
    endtask

    task automatic t_polarity;
        cfg_level_trig[5] = 1'b1; pin_raw[5] = 1'b1; cfg_polarity[5] = 1'b1; cfg_mask[5] = 1'b0;
        expect_idle(4, "R1 inverted raw high inactive");
        pin_raw[5] = 1'b0;
        tick(2);
        expect_req(5, "R1 inverted raw low active");
        complete(4'b0100, 4'b0100, "R12 polarity pin");
        pin_raw[5] = 1'b1;
        send_eoi(8'h35, 1'b1, 8'b0010_0000, "R8 hit on pin 5");
        expect_idle(3, "R1 inactive after EOI");
        cfg_mask[5] = 1'b1; cfg_polarity[5] = 1'b0; pin_raw[5] = 1'b0;
    endtask

    task automatic t_edge;
        cfg_level_trig[2] = 1'b0; cfg_mask[2] = 1'b0;
        pin_raw[2] = 1'b1;
        tick(2);
        expect_req(2, "R3 edge request");
        complete(4'b0100, 4'b0100, "R12 edge injection");
        expect_idle(5, "R3 one delivery per edge");
        pin_raw[2] = 1'b0;
        tick(1);
        pin_raw[2] = 1'b1;
        tick(2);
        expect_req(2, "R3 second edge");
        complete(4'b1000, 4'b1000, "R12 second edge injection");
        pin_raw[2] = 1'b0; cfg_mask[2] = 1'b1;
    endtask

    task automatic t_mask;
        cfg_level_trig[4] = 1'b1; pin_raw[4] = 1'b1;
        expect_idle(5, "R4 masked level pin");
        cfg_level_trig[6] = 1'b0; pin_raw[6] = 1'b1;
        tick(2);
        cfg_mask[6] = 1'b0;
        expect_idle(5, "R4 masked edge discarded");
        pin_raw[6] = 1'b0; pin_raw[4] = 1'b0; cfg_mask[6] = 1'b1;
        tick(1);
    endtask

    task automatic t_arb;
        cfg_level_trig[1] = 1'b0; cfg_level_trig[6] = 1'b0;
        cfg_mask[1] = 1'b0; cfg_mask[6] = 1'b0;
        pin_raw[1] = 1'b1; pin_raw[6] = 1'b1;
        tick(2);
        expect_req(1, "R9 lowest index first");
        complete(4'b0001, 4'b0001, "R12 arb first");
        tick(1);
        expect_req(6, "R9 next pin afterwards");
        complete(4'b0010, 4'b0010, "R12 arb second");
        pin_raw[1] = 1'b0; pin_raw[6] = 1'b0; cfg_mask[1] = 1'b1; cfg_mask[6] = 1'b1;
    endtask

    task automatic t_notarget;
        cfg_level_trig[7] = 1'b1; cfg_mask[7] = 1'b0; pin_raw[7] = 1'b1;
        cpu_present = 4'b0111;
        tick(2);
        expect_req(7, "R6 level request");
        complete(4'b1000, 4'b0000, "R6 absent target injects none");
        tick(1);
        expect_req(7, "R6 redelivered without busy flag");
        complete(4'b1110, 4'b0110, "R12 absent CPU filtered");
        expect_idle(3, "R5 busy after real injection");
        cpu_present = 4'b1111;
        pin_raw[7] = 1'b0;
        send_eoi(8'h37, 1'b1, 8'b1000_0000, "R8 hit on pin 7");
        cfg_mask[7] = 1'b1;
    endtask

    task automatic t_pin0;
        cfg_level_trig[0] = 1'b0; cfg_mask[0] = 1'b0; pin_raw[0] = 1'b1;
        tick(2);
        expect_req(0, "R11 pin 0 request");
        complete(4'b1110, 4'b0001, "R11 pin 0 to CPU 0 only");
        pin_raw[0] = 1'b0; cfg_mask[0] = 1'b1;
    endtask

    task automatic t_shared;
        cfg_vector[3*8 +: 8] = 8'h50; cfg_vector[5*8 +: 8] = 8'h50;
        cfg_level_trig[3] = 1'b1; cfg_level_trig[5] = 1'b1;
        cfg_mask[3] = 1'b0; cfg_mask[5] = 1'b0;
        pin_raw[3] = 1'b1; pin_raw[5] = 1'b1;
        tick(2);
        expect_req(3, "R9 shared first");
        complete(4'b0001, 4'b0001, "R12 shared first");
        tick(1);
        expect_req(5, "R9 shared second");
        complete(4'b0001, 4'b0001, "R12 shared second");
        expect_idle(3, "R5 both busy");
        send_eoi(8'h50, 1'b0, 8'b0010_1000, "R8 edge-type EOI hits both");
        expect_idle(3, "R8 edge-type EOI keeps busy flags");
        send_eoi(8'h50, 1'b1, 8'b0010_1000, "R7 level EOI hits both");
        expect_req(3, "R7 pin 3 redelivered");
        complete(4'b0001, 4'b0001, "R12 pin 3 again");
        tick(1);
        expect_req(5, "R7 pin 5 redelivered");
        complete(4'b0001, 4'b0001, "R12 pin 5 again");
        pin_raw[3] = 1'b0; pin_raw[5] = 1'b0;
        send_eoi(8'h50, 1'b1, 8'b0010_1000, "R8 cleanup hit");
        expect_idle(3, "R7 no redelivery when low");
        cfg_mask[3] = 1'b1; cfg_mask[5] = 1'b1;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            cfg_vector[p*8 +: 8] = 8'(8'h30 + p);
            cfg_dest[p*8 +: 8]   = 8'(8'hA0 + p);
            cfg_dmode[p*3 +: 3]  = 3'(p);
        end
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset;
        t_level;
        t_polarity;
        t_edge;
        t_mask;
        t_arb;
        t_notarget;
        t_pin0;
        t_shared;
        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule